// File: doc/BRIEF.md
# DMA Channel Abort Sequencer

This block holds the control and status bits of one DMA channel and decides when the channel runs, when it stops, and how an abort is carried out. Software writes a small control word: an enable bit, a start bit and an abort bit. It reads back the enable bit, a busy flag, the pending-abort flag and a read-only done flag. The data engine reports each moved long-word with a beat strobe and the natural end of a transfer with a last strobe. In return it receives a run indication and an abort request.

An abort is honoured only when it is written together with enable cleared. Software disables the channel, then writes abort, then waits for done. Once the abort reaches the engine, at most two more beats are allowed before the channel is forced to stop. An abort written while the channel is idle stays latched. It then kills the next DMA that software starts.

The controller has three states. `ST_IDLE` means no transfer. `ST_ACTIVE` means a normal transfer is running. `ST_DRAIN` means an abort was forwarded and the engine is winding down. The transitions are:
- **go**: `ST_IDLE` to `ST_ACTIVE`, on an accepted start with no abort pending.
- **go-killed**: `ST_IDLE` to `ST_DRAIN`, on an accepted start with an abort pending.
- **complete**: `ST_ACTIVE` to `ST_IDLE`, on the last strobe.
- **abort-seen**: `ST_ACTIVE` to `ST_DRAIN`, when the latched abort is observed.
- **drain-end**: `ST_DRAIN` to `ST_IDLE`, on the last strobe or on the second counted beat.

Top module: `dma_abort_seq`

## Requirements
- R1: After reset, cfg_rdata is 0, chan_done is 0, eng_run is 0 and eng_abort is 0.
- R2: The read word has enable at bit 0, busy (channel not idle) at bit 1, pending abort at bit 2 and done at bit 4. Bit 3 reads 0. A write updates the enable bit from cfg_wdata bit 0 at the write edge.
- R3: A write with bit 1 (start) and bit 0 (enable) both set, made while idle, raises eng_run right after that edge and clears done.
- R4: A start write with bit 0 equal to 0 is ignored, so eng_run stays 0.
- R5: In a normal transfer, an eng_last pulse drops eng_run and sets done at the same edge.
- R6: A write with bit 2 (abort) set and bit 0 clear latches the abort. A write with bit 2 and bit 0 both set leaves no abort pending and no eng_abort.
- R7: An abort latched during an active transfer raises eng_abort one cycle after the latching edge, while eng_run stays 1.
- R8: While eng_abort is high, at most two beats are accepted. The second beat ends the channel: eng_run falls and done sets at that edge.
- R9: An eng_last pulse during the drain ends the channel with done set, whatever the beat count.
- R10: An abort latched while idle remains pending. The next accepted start enters the drain at once, with eng_run and eng_abort both 1 right after the start edge.
- R11: The pending-abort flag clears at the edge where done is set.
- R12: A start write while the channel is busy is ignored: the busy flag stays 1, done stays 0 and no abort is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_wdata | input | 3 | Write data: bit0 enable, bit1 start, bit2 abort |
| cfg_rdata | output | 5 | Read data: enable, busy, abort pending, 0, done |
| eng_beat | input | 1 | One long-word moved by the engine |
| eng_last | input | 1 | Engine finished the transfer normally |
| eng_run | output | 1 | Channel is allowed to move data |
| eng_abort | output | 1 | Abort request to the engine |
| chan_done | output | 1 | Done status |

## Verification
The assertions check four things on every cycle. An abort request only appears while the channel is running. The engine never gets more than two beats under an abort. Done only rises as the run indication falls. The abort latch is clear whenever done rises. Only the bench scenarios can show the ordering rules: the disable-then-abort gate, an idle abort killing the following start, and the exact cycle in which the request reaches the engine. The bench also checks that the drain ends on the second beat rather than merely within a bound.

// File: rtl/dma_abt_pkg.sv
package dma_abt_pkg;
    localparam int WR_W     = 3;
    localparam int RD_W     = 5;
    localparam int BIT_EN   = 0;
    localparam int BIT_GO   = 1;
    localparam int BIT_ABT  = 2;
    localparam int BIT_BUSY = 1;
    localparam int BIT_DONE = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DRAIN  = 2'd2
    } chan_state_e;
endpackage

// File: rtl/dma_abt_regs.sv
module dma_abt_regs
    import dma_abt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [WR_W-1:0] cfg_wdata,
    input  logic            abort_clr,
    output logic            en_q,
    output logic            abort_q,
    output logic            start_req
);
    logic abort_set;

    // start only counts when the same write also sets enable
    assign start_req = cfg_wr && cfg_wdata[BIT_GO] && cfg_wdata[BIT_EN];
    // abort only counts when the write leaves the channel disabled
    assign abort_set = cfg_wr && cfg_wdata[BIT_ABT] && !cfg_wdata[BIT_EN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            if (cfg_wr) begin
                en_q <= cfg_wdata[BIT_EN];
            end
            if (abort_set) begin
                abort_q <= 1'b1;
            end else if (abort_clr) begin
                abort_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_abt_fsm.sv
module dma_abt_fsm
    import dma_abt_pkg::*;
#(
    parameter int EXTRA_MAX = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req,
    input  logic        abort_q,
    input  logic        eng_beat,
    input  logic        eng_last,
    output chan_state_e state_q,
    output logic        done_q,
    output logic        abort_clr,
    output logic        eng_run,
    output logic        eng_abort
);
    localparam int CNT_W = $clog2(EXTRA_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(EXTRA_MAX - 1);

    chan_state_e     state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic            done_set;
    logic            done_clr;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        done_set = 1'b0;
        done_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    done_clr = 1'b1;
                    cnt_d    = '0;
                    state_d  = abort_q ? ST_DRAIN : ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (eng_last) begin
                    done_set = 1'b1;
                    state_d  = ST_IDLE;
                end else if (abort_q) begin
                    cnt_d   = '0;
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (eng_last || (eng_beat && cnt_q == CNT_END)) begin
                    done_set = 1'b1;
                    state_d  = ST_IDLE;
                end else if (eng_beat) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (done_set) begin
                done_q <= 1'b1;
            end else if (done_clr) begin
                done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        abort_clr = done_set;
        unique case (state_q)
            ST_IDLE:   begin eng_run = 1'b0; eng_abort = 1'b0; end
            ST_ACTIVE: begin eng_run = 1'b1; eng_abort = 1'b0; end
            ST_DRAIN:  begin eng_run = 1'b1; eng_abort = 1'b1; end
            default:   begin eng_run = 1'b0; eng_abort = 1'b0; end
        endcase
    end
endmodule

// File: rtl/dma_abort_seq.sv
module dma_abort_seq
    import dma_abt_pkg::*;
#(
    parameter int EXTRA_MAX = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [WR_W-1:0] cfg_wdata,
    output logic [RD_W-1:0] cfg_rdata,
    input  logic            eng_beat,
    input  logic            eng_last,
    output logic            eng_run,
    output logic            eng_abort,
    output logic            chan_done
);
    logic        en_q;
    logic        abort_q;
    logic        start_req;
    logic        abort_clr;
    logic        done_q;
    chan_state_e state_q;

    dma_abt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .abort_clr (abort_clr),
        .en_q      (en_q),
        .abort_q   (abort_q),
        .start_req (start_req)
    );

    dma_abt_fsm #(.EXTRA_MAX(EXTRA_MAX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .abort_q   (abort_q),
        .eng_beat  (eng_beat),
        .eng_last  (eng_last),
        .state_q   (state_q),
        .done_q    (done_q),
        .abort_clr (abort_clr),
        .eng_run   (eng_run),
        .eng_abort (eng_abort)
    );

    always_comb begin
        cfg_rdata           = '0;
        cfg_rdata[BIT_EN]   = en_q;
        cfg_rdata[BIT_BUSY] = (state_q != ST_IDLE);
        cfg_rdata[BIT_ABT]  = abort_q;
        cfg_rdata[BIT_DONE] = done_q;
    end

    assign chan_done = done_q;
endmodule

// File: rtl/dma_abort_seq_chk.sv
module dma_abort_seq_chk #(
    parameter int EXTRA_MAX = 2
) (
    input logic clk,
    input logic rst_n,
    input logic eng_beat,
    input logic eng_run,
    input logic eng_abort,
    input logic chan_done,
    input logic abort_q
);
    localparam int BW = $clog2(EXTRA_MAX + 2) + 1;
    logic [BW-1:0] abt_beats;

    always_ff @(posedge clk) begin
        if (!rst_n || !eng_abort) begin
            abt_beats <= '0;
        end else if (eng_beat) begin
            abt_beats <= abt_beats + 1'b1;
        end
    end

    // R7: the abort request is only ever shown to a running channel
    assert_abort_while_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> eng_run);

    // R8: beats accepted under an abort stay within the allowance
    assert_drain_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> (int'(abt_beats) < EXTRA_MAX));

    // R5: done appears exactly as the channel stops
    assert_done_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_done) |-> $fell(eng_run));

    // R11: the abort latch never survives a rising done
    assert_abort_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_done) |-> !abort_q);

    // R3: done is never set while the channel runs
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_run |-> !chan_done);
endmodule

bind dma_abort_seq dma_abort_seq_chk #(.EXTRA_MAX(EXTRA_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_beat  (eng_beat),
    .eng_run   (eng_run),
    .eng_abort (eng_abort),
    .chan_done (chan_done),
    .abort_q   (abort_q)
);

// File: tb/tb_dma_abort_seq.sv
module tb_dma_abort_seq;
    localparam int CLK_PERIOD = 10;
    localparam int EXTRA_MAX  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic [4:0] cfg_rdata;
    logic       eng_beat = 1'b0;
    logic       eng_last = 1'b0;
    logic       eng_run;
    logic       eng_abort;
    logic       chan_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_abort_seq #(.EXTRA_MAX(EXTRA_MAX)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .eng_beat(eng_beat), .eng_last(eng_last),
        .eng_run(eng_run), .eng_abort(eng_abort), .chan_done(chan_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // read word from the R2 layout: en bit0, busy bit1, abort bit2, done bit4
    function automatic int rd_word(input bit en, input bit busy, input bit abt, input bit dn);
        return (int'(dn) << 4) | (int'(abt) << 2) | (int'(busy) << 1) | int'(en);
    endfunction

    // beats until the drain ends: last at position k (k < EXTRA_MAX) or the allowance
    function automatic int drain_len(input int last_at);
        return (last_at < EXTRA_MAX) ? last_at : EXTRA_MAX;
    endfunction

    task automatic wr(input logic [2:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pulse(input bit b, input bit l);
        @(negedge clk); eng_beat = b; eng_last = l;
        @(negedge clk); eng_beat = 1'b0; eng_last = 1'b0;
    endtask

    task automatic idle1();
        @(negedge clk);
    endtask

    task automatic start_norm();
        wr(3'b011);
        chk("R3 run", int'(eng_run), 1);
        chk("R3 done cleared", int'(chan_done), 0);
    endtask

    task automatic abort_active(input int pre, input int last_at);
        int n;
        start_norm();
        for (int i = 0; i < pre; i++) pulse(1'b1, 1'b0);
        wr(3'b000);
        wr(3'b100);
        chk("R6 abort latched", int'(cfg_rdata[2]), 1);
        chk("R7 not yet", int'(eng_abort), 0);
        idle1();
        chk("R7 abort req", int'(eng_abort), 1);
        chk("R7 still run", int'(eng_run), 1);
        n = drain_len(last_at);
        for (int i = 0; i < n; i++) begin
            pulse(1'b1, 1'b0);
            chk("R8 run during drain", int'(eng_run), (i + 1 < EXTRA_MAX) ? 1 : 0);
        end
        if (last_at < EXTRA_MAX) begin
            pulse(1'b0, 1'b1);
            chk("R9 last ends drain", int'(eng_run), 0);
        end
        chk("R8 done", int'(chan_done), 1);
        chk("R11 abort clear", int'(cfg_rdata[2]), 0);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", int'(cfg_rdata), 0);
        chk("R1 done", int'(chan_done), 0);
        chk("R1 run", int'(eng_run), 0);
        chk("R1 abort", int'(eng_abort), 0);

        // R4: start without enable
        wr(3'b010);
        chk("R4 ignored", int'(eng_run), 0);
        chk("R2 enable clear", int'(cfg_rdata), rd_word(0, 0, 0, 0));

        // R2/R3/R5 normal run
        wr(3'b011);
        chk("R2 readback", int'(cfg_rdata), rd_word(1, 1, 0, 0));
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        chk("R5 run", int'(eng_run), 0);
        chk("R5 done", int'(chan_done), 1);
        chk("R2 done bit", int'(cfg_rdata), rd_word(1, 0, 0, 1));

        // R12 restart while busy, R6 abort with enable set is ignored
        start_norm();
        wr(3'b011);
        chk("R12 busy", int'(cfg_rdata[1]), 1);
        chk("R12 done", int'(chan_done), 0);
        wr(3'b101);
        chk("R6 no latch", int'(cfg_rdata[2]), 0);
        idle1();
        chk("R6 no abort", int'(eng_abort), 0);
        pulse(1'b0, 1'b1);

        // R8 full drain, R9 early last
        abort_active(1, 3);
        abort_active(0, 1);
        abort_active(2, 0);

        // R10 idle abort kills next start
        wr(3'b100);
        idle1(); idle1();
        chk("R10 pending", int'(cfg_rdata), rd_word(0, 0, 1, 1));
        chk("R10 idle", int'(eng_run), 0);
        wr(3'b011);
        chk("R10 run", int'(eng_run), 1);
        chk("R10 abort", int'(eng_abort), 1);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        chk("R10 done", int'(chan_done), 1);
        chk("R11 clear", int'(cfg_rdata[2]), 0);

        // constrained random scenarios
        for (int it = 0; it < 40; it++) begin
            int mode = int'($urandom % 3);
            int pre  = int'($urandom % 4);
            int la   = int'($urandom % 3);
            if (mode == 0) begin
                start_norm();
                for (int i = 0; i < pre; i++) begin
                    pulse(1'b1, 1'b0);
                    chk("R5 run held", int'(eng_run), 1);
                end
                pulse(1'b0, 1'b1);
                chk("R5 done", int'(chan_done), 1);
            end else if (mode == 1) begin
                abort_active(pre, la);
            end else begin
                wr(3'b100);
                chk("R10 latched", int'(cfg_rdata[2]), 1);
                wr(3'b011);
                chk("R10 direct drain", int'(eng_abort), 1);
                for (int i = 0; i < drain_len(la); i++) pulse(1'b1, 1'b0);
                if (la < EXTRA_MAX) pulse(1'b0, 1'b1);
                chk("R9 done", int'(chan_done), 1);
                chk("R11 clear", int'(cfg_rdata[2]), 0);
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule